// File: doc/BRIEF.md
# Raster Timing and Fetch Sequencer

This block keeps the beam position of a tile-based video generator that produces one pixel per clock. It counts clocks within a scanline and scanlines within a frame. From those two counts it decodes, every clock, which kind of external memory access the rendering engine should be making. The access can be a tile name, an attribute byte, one of the two background pattern planes, a throw-away name read, or one of the two object pattern planes. Each access lasts two clocks. The block also reports the slot index and which half of the access is under way.

The same counters drive the vertical-blank status flag and a one-clock interrupt pulse. They also drive a strobe that marks visible pixels, and a qualifier that says when memory traffic is allowed. A frame-parity bit lets the dummy line that precedes the picture drop its final idle clock on every second frame. This happens only while rendering is on.

The vertical layout is set by two parameters: the number of blanking lines (default 20) and the number of visible lines (default 240). The line that follows the blanking lines is the dummy line. After the visible lines comes one idle line, so the default frame is 262 lines. The horizontal layout is 341 clocks per line and is fixed.

Top module: `raster_fetch_seq`

## Requirements
- R1: The clock counter `cycle_o` runs 0 to 340 and then returns to 0. Each time it returns to 0, `line_o` advances.
- R2: `line_o` runs 0 to VBLANK_LINES+VISIBLE_LINES+1 and then wraps to 0. `odd_frame_o` inverts at every wrap. Reset puts the clock count, line count, parity, `vblank_o` and `nmi_o` to 0.
- R3: On the dummy line (line VBLANK_LINES), the line ends after clock 339 when `odd_frame_o` is 1 and `render_en` is 1 at that clock. Otherwise the dummy line is 341 clocks long, like every other line.
- R4: While fetching, slots 0 to 127 follow slot mod 4: 0 gives name (code 1), 1 gives attribute (2), 2 gives pattern low (3), 3 gives pattern high (4).
- R5: While fetching, slots 128 to 159 follow slot mod 4: 0 and 1 give a discarded name read (code 5), 2 gives object pattern low (6), 3 gives object pattern high (7).
- R6: While fetching, slots 160 to 167 repeat the R4 pattern. Slots 168 and 169 are name reads (code 1). Clock 340 is idle (code 0).
- R7: `fetch_kind_o` is idle (code 0) and `render_active_o` is 0 whenever `render_en` is 0 or the line lies outside the dummy line and the visible lines. On those lines, with `render_en` at 1, `render_active_o` is 1.
- R8: `fetch_slot_o` equals `cycle_o` divided by 2. `fetch_phase_o` is 0 on the address clock of an access and 1 on its data clock.
- R9: `pixel_visible_o` is 1 exactly on lines VBLANK_LINES+1 through VBLANK_LINES+VISIBLE_LINES at clocks 0 to 255.
- R10: `vblank_o` becomes 1 on the clock where the count moves from the end of the idle line to line 0, clock 0. It becomes 0 after a `status_rd` clock or on entry to the dummy line. Setting takes precedence over a read made in the same clock.
- R11: `nmi_o` is a one-clock pulse in the clock where `vblank_o` rises, issued only if `nmi_en` was 1. It does not depend on `status_rd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| render_en | input | 1 | Rendering enabled (background or objects) |
| nmi_en | input | 1 | Allows the vertical interrupt pulse |
| status_rd | input | 1 | One-clock strobe: status has been read |
| cycle_o | output | 9 | Clock within the line, 0..340 |
| line_o | output | 9 | Line within the frame |
| odd_frame_o | output | 1 | Frame parity |
| fetch_kind_o | output | 3 | Access kind code (see R4 to R7) |
| fetch_slot_o | output | 8 | Access slot index, 0..170 |
| fetch_phase_o | output | 1 | 0 = address clock, 1 = data clock |
| render_active_o | output | 1 | Memory traffic allowed on this line |
| pixel_visible_o | output | 1 | Current clock produces an on-screen pixel |
| vblank_o | output | 1 | Vertical-blank status flag |
| nmi_o | output | 1 | Vertical interrupt pulse |

## Verification
The assertions check these rules on every clock:
- the clock count wraps after 340,
- a line can be shortened only on an odd dummy line with rendering on,
- `vblank_o` rises only at line 0 clock 0,
- `nmi_o` is seen only together with `vblank_o`,
- the fetch kind is idle whenever rendering is off,
- a visible pixel never occurs during vertical blank.

The exact sequence of access kinds within a line needs the bench's clock-by-clock model. So do the interaction of status reads with the set edge and the length of dummy lines across consecutive frames. The bench drives directed frames in which the odd dummy line is shortened and frames in which the shortening is suppressed.

// File: rtl/raster_pkg.sv
package raster_pkg;

    localparam int CNT_W  = 9;
    localparam int SLOT_W = 8;

    localparam logic [CNT_W-1:0]  H_LAST       = 9'd340;
    localparam logic [CNT_W-1:0]  H_SKIP_LAST  = 9'd339;
    localparam logic [CNT_W-1:0]  H_VISIBLE    = 9'd256;

    localparam logic [SLOT_W-1:0] SLOT_BG_END  = 8'd128;
    localparam logic [SLOT_W-1:0] SLOT_OBJ_END = 8'd160;
    localparam logic [SLOT_W-1:0] SLOT_PRE_END = 8'd168;

    typedef enum logic [2:0] {
        FK_IDLE     = 3'd0,
        FK_NAME     = 3'd1,
        FK_ATTR     = 3'd2,
        FK_PAT_LO   = 3'd3,
        FK_PAT_HI   = 3'd4,
        FK_NAME_X   = 3'd5,
        FK_OBJ_LO   = 3'd6,
        FK_OBJ_HI   = 3'd7
    } fetch_kind_t;

    // Access kind for a slot, assuming fetching is allowed.
    function automatic fetch_kind_t slot_kind(input logic [SLOT_W-1:0] slot);
        fetch_kind_t k;
        if (slot >= SLOT_PRE_END) begin
            k = FK_NAME;
        end else if (slot >= SLOT_BG_END && slot < SLOT_OBJ_END) begin
            unique case (slot[1:0])
                2'd0, 2'd1: k = FK_NAME_X;
                2'd2:       k = FK_OBJ_LO;
                default:    k = FK_OBJ_HI;
            endcase
        end else begin
            unique case (slot[1:0])
                2'd0:    k = FK_NAME;
                2'd1:    k = FK_ATTR;
                2'd2:    k = FK_PAT_LO;
                default: k = FK_PAT_HI;
            endcase
        end
        return k;
    endfunction

endpackage

// File: rtl/raster_counter.sv
module raster_counter
    import raster_pkg::*;
#(
    parameter int VBLANK_LINES  = 20,
    parameter int VISIBLE_LINES = 240
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             render_en,
    output logic [CNT_W-1:0] cycle,
    output logic [CNT_W-1:0] line,
    output logic             odd
);

    localparam logic [CNT_W-1:0] DUMMY_LINE = CNT_W'(VBLANK_LINES);
    localparam logic [CNT_W-1:0] LAST_LINE  = CNT_W'(VBLANK_LINES + VISIBLE_LINES + 1);

    logic short_end;
    logic line_end;

    assign short_end = (cycle == H_SKIP_LAST) && (line == DUMMY_LINE) && odd && render_en;
    assign line_end  = (cycle == H_LAST) || short_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            cycle <= '0;
            line  <= '0;
            odd   <= 1'b0;
        end else if (line_end) begin
            cycle <= '0;
            if (line == LAST_LINE) begin
                line <= '0;
                odd  <= ~odd;
            end else begin
                line <= line + 1'b1;
            end
        end else begin
            cycle <= cycle + 1'b1;
        end
    end

    AST_CYCLE_WRAP: assert property (@(posedge clk) disable iff (rst)
        (cycle == H_LAST) |=> (cycle == '0)) else $error("cycle did not wrap"); // R1

    AST_SHORT_LINE_QUAL: assert property (@(posedge clk) disable iff (rst)
        (cycle == H_SKIP_LAST && !(line == DUMMY_LINE && odd && render_en))
        |=> (cycle == H_LAST)) else $error("unexpected short line"); // R3

    AST_PARITY_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (line == LAST_LINE && cycle == H_LAST) |=> (odd != $past(odd))) else $error("parity"); // R2

endmodule

// File: rtl/fetch_decoder.sv
module fetch_decoder
    import raster_pkg::*;
#(
    parameter int VBLANK_LINES  = 20,
    parameter int VISIBLE_LINES = 240
) (
    input  logic              render_en,
    input  logic [CNT_W-1:0]  cycle,
    input  logic [CNT_W-1:0]  line,
    output fetch_kind_t       kind,
    output logic [SLOT_W-1:0] slot,
    output logic              phase,
    output logic              active,
    output logic              visible
);

    localparam logic [CNT_W-1:0] DUMMY_LINE = CNT_W'(VBLANK_LINES);
    localparam logic [CNT_W-1:0] FIRST_VIS  = CNT_W'(VBLANK_LINES + 1);
    localparam logic [CNT_W-1:0] LAST_VIS   = CNT_W'(VBLANK_LINES + VISIBLE_LINES);

    logic fetch_lines;

    assign slot        = cycle[CNT_W-1:1];
    assign phase       = cycle[0];
    assign fetch_lines = (line >= DUMMY_LINE) && (line <= LAST_VIS);
    assign active      = render_en && fetch_lines;
    assign visible     = (line >= FIRST_VIS) && (line <= LAST_VIS) && (cycle < H_VISIBLE);

    always_comb begin
        if (active && cycle != H_LAST) kind = slot_kind(slot);
        else                           kind = FK_IDLE;
    end

endmodule

// File: rtl/vblank_ctrl.sv
module vblank_ctrl
    import raster_pkg::*;
#(
    parameter int VBLANK_LINES  = 20,
    parameter int VISIBLE_LINES = 240
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cycle,
    input  logic [CNT_W-1:0] line,
    input  logic             nmi_en,
    input  logic             status_rd,
    output logic             vblank,
    output logic             nmi
);

    localparam logic [CNT_W-1:0] PRE_DUMMY = CNT_W'(VBLANK_LINES - 1);
    localparam logic [CNT_W-1:0] LAST_LINE = CNT_W'(VBLANK_LINES + VISIBLE_LINES + 1);

    logic frame_end;
    logic dummy_enter;

    assign frame_end   = (cycle == H_LAST) && (line == LAST_LINE);
    assign dummy_enter = (cycle == H_LAST) && (line == PRE_DUMMY);

    always_ff @(posedge clk) begin
        if (rst) begin
            vblank <= 1'b0;
            nmi    <= 1'b0;
        end else begin
            if (frame_end)                     vblank <= 1'b1;
            else if (dummy_enter || status_rd) vblank <= 1'b0;
            nmi <= frame_end && nmi_en;
        end
    end

    AST_VBL_RISE_POS: assert property (@(posedge clk) disable iff (rst)
        $rose(vblank) |-> (cycle == '0 && line == '0)) else $error("vblank rose off frame start"); // R10

    AST_NMI_WITH_VBL: assert property (@(posedge clk) disable iff (rst)
        nmi |-> (vblank && $past(nmi_en))) else $error("nmi without vblank"); // R11

    AST_NMI_SINGLE: assert property (@(posedge clk) disable iff (rst)
        nmi |=> !nmi) else $error("nmi longer than one clock"); // R11

endmodule

// File: rtl/raster_fetch_seq.sv
module raster_fetch_seq
    import raster_pkg::*;
#(
    parameter int VBLANK_LINES  = 20,
    parameter int VISIBLE_LINES = 240
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       render_en,
    input  logic       nmi_en,
    input  logic       status_rd,
    output logic [8:0] cycle_o,
    output logic [8:0] line_o,
    output logic       odd_frame_o,
    output logic [2:0] fetch_kind_o,
    output logic [7:0] fetch_slot_o,
    output logic       fetch_phase_o,
    output logic       render_active_o,
    output logic       pixel_visible_o,
    output logic       vblank_o,
    output logic       nmi_o
);

    logic [CNT_W-1:0] cycle;
    logic [CNT_W-1:0] line;
    fetch_kind_t      kind;

    raster_counter #(
        .VBLANK_LINES (VBLANK_LINES),
        .VISIBLE_LINES(VISIBLE_LINES)
    ) u_counter (
        .clk      (clk),
        .rst      (rst),
        .render_en(render_en),
        .cycle    (cycle),
        .line     (line),
        .odd      (odd_frame_o)
    );

    fetch_decoder #(
        .VBLANK_LINES (VBLANK_LINES),
        .VISIBLE_LINES(VISIBLE_LINES)
    ) u_decoder (
        .render_en(render_en),
        .cycle    (cycle),
        .line     (line),
        .kind     (kind),
        .slot     (fetch_slot_o),
        .phase    (fetch_phase_o),
        .active   (render_active_o),
        .visible  (pixel_visible_o)
    );

    vblank_ctrl #(
        .VBLANK_LINES (VBLANK_LINES),
        .VISIBLE_LINES(VISIBLE_LINES)
    ) u_vblank (
        .clk      (clk),
        .rst      (rst),
        .cycle    (cycle),
        .line     (line),
        .nmi_en   (nmi_en),
        .status_rd(status_rd),
        .vblank   (vblank_o),
        .nmi      (nmi_o)
    );

    assign cycle_o      = cycle;
    assign line_o       = line;
    assign fetch_kind_o = kind;

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !render_en |-> (fetch_kind_o == 3'd0 && !render_active_o)) else $error("fetch while off"); // R7

    AST_NO_PIXEL_IN_VBL: assert property (@(posedge clk) disable iff (rst)
        pixel_visible_o |-> !vblank_o) else $error("visible pixel in vblank"); // R9

endmodule

// File: tb/test_raster_fetch_seq.sv
module test_raster_fetch_seq;

    localparam int VBL   = 3;
    localparam int VIS   = 4;
    localparam int DUMMY = VBL;
    localparam int FVIS  = VBL + 1;
    localparam int LVIS  = VBL + VIS;
    localparam int LAST  = VBL + VIS + 1;
    localparam int ITER  = 40000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       render_en = 1'b0;
    logic       nmi_en = 1'b0;
    logic       status_rd = 1'b0;
    logic [8:0] cycle_o, line_o;
    logic       odd_frame_o;
    logic [2:0] fetch_kind_o;
    logic [7:0] fetch_slot_o;
    logic       fetch_phase_o, render_active_o, pixel_visible_o, vblank_o, nmi_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int m_cyc = 0, m_line = 0, m_odd = 0, m_vbl = 0, m_nmi = 0, fc = 0;
    int skips_taken = 0, skips_blocked = 0, nmi_seen = 0, nmi_blocked = 0;

    always #10 clk = ~clk;

    raster_fetch_seq #(.VBLANK_LINES(VBL), .VISIBLE_LINES(VIS)) i_raster_fetch_seq (
        .clk(clk), .rst(rst), .render_en(render_en), .nmi_en(nmi_en), .status_rd(status_rd),
        .cycle_o(cycle_o), .line_o(line_o), .odd_frame_o(odd_frame_o),
        .fetch_kind_o(fetch_kind_o), .fetch_slot_o(fetch_slot_o), .fetch_phase_o(fetch_phase_o),
        .render_active_o(render_active_o), .pixel_visible_o(pixel_visible_o),
        .vblank_o(vblank_o), .nmi_o(nmi_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s act=%0d exp=%0d (line %0d cycle %0d)", req, what, act, exp, m_line, m_cyc);
        end
    endtask

    // R4 R5 R6 R7: expected access code from the requirement text
    function automatic int exp_kind(input int cyc, input int ln, input bit ren);
        int s;
        if (!ren || ln < DUMMY || ln > LVIS || cyc == 340) return 0;
        s = cyc / 2;
        if (s >= 168) return 1;
        if (s >= 128 && s < 160) begin
            if ((s % 4) < 2) return 5;
            return (s % 4 == 2) ? 6 : 7;
        end
        return 1 + (s % 4);
    endfunction

    function automatic bit exp_visible(input int cyc, input int ln);
        return (ln >= FVIS && ln <= LVIS && cyc < 256);
    endfunction

    task automatic check_all();
        bit act_exp;
        act_exp = render_en && m_line >= DUMMY && m_line <= LVIS;
        chk("R1", "cycle", int'(cycle_o), m_cyc);
        chk("R2", "line", int'(line_o), m_line);
        chk("R2", "odd", int'(odd_frame_o), m_odd);
        chk("R4", "kind", int'(fetch_kind_o), exp_kind(m_cyc, m_line, render_en));
        chk("R8", "slot", int'(fetch_slot_o), m_cyc / 2);
        chk("R8", "phase", int'(fetch_phase_o), m_cyc % 2);
        chk("R7", "active", int'(render_active_o), int'(act_exp));
        chk("R9", "visible", int'(pixel_visible_o), int'(exp_visible(m_cyc, m_line)));
        chk("R10", "vblank", int'(vblank_o), m_vbl);
        chk("R11", "nmi", int'(nmi_o), m_nmi);
    endtask

    // advance the model across one rising edge using the current inputs
    task automatic step_model();
        bit fe, skip;
        fe   = (m_cyc == 340 && m_line == LAST);
        skip = (m_line == DUMMY && m_odd == 1 && render_en && m_cyc == 339);
        if (m_line == DUMMY && m_odd == 1 && m_cyc == 339) begin
            if (render_en) skips_taken++;
            else           skips_blocked++;
        end
        if (fe) begin
            m_vbl = 1;
            if (nmi_en) nmi_seen++; else nmi_blocked++;
        end else if ((m_line == DUMMY - 1 && m_cyc == 340) || status_rd) begin
            m_vbl = 0;
        end
        m_nmi = (fe && nmi_en) ? 1 : 0;
        if (m_cyc == 340 || skip) begin
            m_cyc = 0;
            if (m_line == LAST) begin
                m_line = 0;
                m_odd ^= 1;
                fc++;
            end else begin
                m_line++;
            end
        end else begin
            m_cyc++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1c3d));
        render_en = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R2: reset state
        chk("R2", "reset cycle", int'(cycle_o), 0);
        chk("R2", "reset line", int'(line_o), 0);
        chk("R2", "reset odd", int'(odd_frame_o), 0);
        chk("R2", "reset vblank", int'(vblank_o), 0);
        chk("R2", "reset nmi", int'(nmi_o), 0);

        for (int i = 0; i < ITER; i++) begin
            // render enable: random per line, directed on dummy lines
            if (m_cyc == 0) render_en = ($urandom % 4) != 0;
            if (m_line == DUMMY) render_en = (fc != 3 && fc != 7);   // R3: frames 3,7 block the skip
            nmi_en    = (fc % 3) != 2;                              // R11: some frames masked
            status_rd = ($urandom % 150) == 0;
            if (m_line == 1 && m_cyc == 5 && fc == 4) status_rd = 1'b1;            // R10 directed read
            if (m_line == LAST && m_cyc == 340 && fc == 5) status_rd = 1'b1;       // R10 read at set edge
            #1;
            check_all();
            step_model();
            @(negedge clk);
        end
        #1;
        check_all();
        // coverage of the corner cases the requirements call out
        chk("R3", "odd dummy lines shortened", int'(skips_taken > 0), 1);
        chk("R3", "odd dummy lines kept full", int'(skips_blocked > 0), 1);
        chk("R11", "pulses issued", int'(nmi_seen > 0), 1);
        chk("R11", "pulses masked", int'(nmi_blocked > 0), 1);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule